// File: doc/BRIEF.md
# CAS-before-RAS Refresh Engine

This block keeps a 72-pin fast-page-mode DRAM module refreshed with CAS-before-RAS cycles. The module's internal row counter picks the row, so no address is driven. A free-running interval timer adds one refresh to a small pending count every refresh interval. The interval comes from the retention time divided by the number of rows: 16 ms over 1024 rows gives about 15.6 µs. While the count is non-zero and the engine is idle, it raises a request to the memory arbiter. When the arbiter grants, the engine takes the strobes and runs one refresh cycle. All CAS lanes fall first, then all RAS lanes fall, CAS is released, RAS is released after the minimum pulse width, and RAS then precharges before the engine goes idle again.

Every timing is given in nanoseconds and turned into clock cycles at elaboration, rounded up, with a floor of one cycle. The interval is rounded down so that refreshes never come late. When four or more refreshes are waiting, an urgency flag tells the arbiter to cut a page-mode burst short. Write enable stays high for the whole cycle, so a refresh can never be taken for a write. All four RAS lanes and all four CAS lanes switch together, so both module sides and every byte lane refresh in the same cycle.

Top module: `cbr_refresh_engine`

## Requirements
- R1: `refReq` rises for the first time exactly INTERVAL cycles after reset is released, where INTERVAL = floor((RETENTION_NS/ROW_COUNT)·1000/CLK_PERIOD_PS). One more refresh then becomes due every INTERVAL cycles.
- R2: Directly after reset, `rasN` and `casN` are all ones, `weN` is 1, and `refReq`, `refBusy` and `refUrgent` are 0.
- R3: A grant accepted while idle with work pending pulls every `casN` lane low in the next cycle. The lanes stay low for LEAD = max(ceil(T_CSR), ceil(T_WRP)) cycles before RAS falls, and then for HOLD = max(ceil(T_CHR), ceil(T_WRH)) further cycles.
- R4: Every `rasN` lane is low for RAS = max(ceil(T_RAS), HOLD+1) cycles, starting LEAD cycles after CAS fell. RAS never stays low longer than T_RAS_MAX_NS.
- R5: `weN` stays 1 before, during and after every RAS falling edge.
- R6: After RAS rises, `refBusy` stays 1 for PRECH = ceil(T_RP) cycles with all strobes high. `refReq` is 0 whenever `refBusy` is 1.
- R7: All RAS lanes carry the same value, and so do all CAS lanes.
- R8: The pending count saturates at MAX_PENDING (8). Intervals that elapse while the count is full are dropped, so exactly MAX_PENDING refreshes drain before `refReq` falls.
- R9: `refUrgent` is 1 exactly while the pending count is at least URGENT_LEVEL (4).
- R10: A grant is ignored while the pending count is zero or while a refresh is in progress. Such a grant starts no cycle and consumes no pending refresh.
- R11: When a new interval elapses in the same cycle that a grant is accepted, the pending count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Arbiter grant; sampled while idle |
| refReq | output | 1 | Refresh wanted (idle and pending count non-zero) |
| refUrgent | output | 1 | Pending count at or above the urgency level |
| refBusy | output | 1 | Engine owns the strobes (cycle or precharge in progress) |
| rasN | output | LANES | Row strobes, active low, all lanes equal |
| casN | output | LANES | Column strobes, active low, all lanes equal |
| weN | output | 1 | Write enable, held high |

## Verification
The strobe order is checked cycle by cycle after a grant: CAS alone, CAS with RAS, RAS alone, precharge, idle. A wrong phase length or a swapped edge therefore shows up in a specific cycle. Grants are also applied with no work pending and in the middle of a busy cycle. Both must be ignored, which is seen when `refReq` drops after the expected number of refreshes. A long run with no grant fills the counter past its limit, and draining it one refresh at a time tells saturation apart from wrap-around or overcounting, while also crossing the urgency threshold in both directions. A final pattern lines up a grant with the exact cycle in which an interval elapses, to expose a counter that loses or doubles a refresh when both happen together.

// File: rtl/cbr_refresh_pkg.sv
`timescale 1ns/1ps
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_HOLD  = 3'd2,
    PH_TAIL  = 3'd3,
    PH_PRECH = 3'd4
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   take;      // consume one pending refresh
    logic   load;      // reload the phase timer
    phase_e nextPhase; // phase whose length is loaded
  } ctrl_strobe_t;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned periodPs);
    int unsigned c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_datapath.sv
`timescale 1ns/1ps
module refresh_datapath
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned LEAD_CYC     = 1,
  parameter int unsigned HOLD_CYC     = 1,
  parameter int unsigned TAIL_CYC     = 5,
  parameter int unsigned PRECH_CYC    = 4,
  parameter int unsigned INTERVAL_CYC = 1562,
  parameter int unsigned MAX_PENDING  = 8,
  parameter int unsigned URGENT_LEVEL = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t ctrl,
  output logic         phaseDone,
  output logic         pendingAny,
  output logic         urgent
);

  localparam int unsigned PEND_W  = $clog2(MAX_PENDING + 1);
  localparam int unsigned INT_W   = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned MAX_LEN = max2(max2(LEAD_CYC, HOLD_CYC), max2(TAIL_CYC, PRECH_CYC));
  localparam int unsigned PH_W    = $clog2(MAX_LEN + 1);

  logic [INT_W-1:0]  intervalCnt;
  logic              intervalTick;
  logic [PEND_W-1:0] pending;
  logic              takeOk;
  logic [PH_W-1:0]   phaseCnt;
  logic [PH_W-1:0]   loadVal;

  // free-running interval timer
  assign intervalTick = (intervalCnt == INT_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN)             intervalCnt <= '0;
    else if (intervalTick) intervalCnt <= '0;
    else                   intervalCnt <= intervalCnt + 1'b1;
  end

  // saturating pending counter
  assign takeOk = ctrl.take && (pending != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      unique case ({intervalTick, takeOk})
        2'b10: if (pending != PEND_W'(MAX_PENDING)) pending <= pending + 1'b1;
        2'b01: pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  assign pendingAny = (pending != '0);
  assign urgent     = (pending >= PEND_W'(URGENT_LEVEL));

  // phase timer: loaded with length-1, counts down to zero
  always_comb begin
    unique case (ctrl.nextPhase)
      PH_LEAD:  loadVal = PH_W'(LEAD_CYC - 1);
      PH_HOLD:  loadVal = PH_W'(HOLD_CYC - 1);
      PH_TAIL:  loadVal = PH_W'(TAIL_CYC - 1);
      PH_PRECH: loadVal = PH_W'(PRECH_CYC - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= '0;
    else if (ctrl.load)       phaseCnt <= loadVal;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseDone = (phaseCnt == '0);

endmodule

// File: rtl/refresh_ctrl.sv
`timescale 1ns/1ps
module refresh_ctrl
  import cbr_refresh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         refGrant,
  input  logic         phaseDone,
  input  logic         pendingAny,
  output ctrl_strobe_t ctrl,
  output logic         refReq,
  output logic         refBusy,
  output logic         casActive,
  output logic         rasActive
);

  phase_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '{take: 1'b0, load: 1'b0, nextPhase: PH_IDLE};
    unique case (state)
      PH_IDLE: begin
        if (refGrant && pendingAny) begin
          nextState      = PH_LEAD;
          ctrl.take      = 1'b1;
          ctrl.load      = 1'b1;
          ctrl.nextPhase = PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (phaseDone) begin
          nextState      = PH_HOLD;
          ctrl.load      = 1'b1;
          ctrl.nextPhase = PH_HOLD;
        end
      end
      PH_HOLD: begin
        if (phaseDone) begin
          nextState      = PH_TAIL;
          ctrl.load      = 1'b1;
          ctrl.nextPhase = PH_TAIL;
        end
      end
      PH_TAIL: begin
        if (phaseDone) begin
          nextState      = PH_PRECH;
          ctrl.load      = 1'b1;
          ctrl.nextPhase = PH_PRECH;
        end
      end
      PH_PRECH: begin
        if (phaseDone) nextState = PH_IDLE;
      end
      default: nextState = PH_IDLE;
    endcase
  end

  assign casActive = (state == PH_LEAD) || (state == PH_HOLD);
  assign rasActive = (state == PH_HOLD) || (state == PH_TAIL);
  assign refBusy   = (state != PH_IDLE);
  assign refReq    = (state == PH_IDLE) && pendingAny;

endmodule

// File: rtl/cbr_refresh_engine.sv
`timescale 1ns/1ps
module cbr_refresh_engine
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned RETENTION_NS  = 16000000,
  parameter int unsigned ROW_COUNT     = 1024,
  parameter int unsigned T_CSR_NS      = 5,
  parameter int unsigned T_WRP_NS      = 10,
  parameter int unsigned T_CHR_NS      = 10,
  parameter int unsigned T_WRH_NS      = 10,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned MAX_PENDING   = 8,
  parameter int unsigned URGENT_LEVEL  = 4,
  parameter int unsigned LANES         = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGrant,
  output logic             refReq,
  output logic             refUrgent,
  output logic             refBusy,
  output logic [LANES-1:0] rasN,
  output logic [LANES-1:0] casN,
  output logic             weN
);

  localparam int unsigned LEAD_CYC  = max2(ns_to_cycles(T_CSR_NS, CLK_PERIOD_PS),
                                           ns_to_cycles(T_WRP_NS, CLK_PERIOD_PS));
  localparam int unsigned HOLD_CYC  = max2(ns_to_cycles(T_CHR_NS, CLK_PERIOD_PS),
                                           ns_to_cycles(T_WRH_NS, CLK_PERIOD_PS));
  localparam int unsigned RAS_CYC   = max2(ns_to_cycles(T_RAS_NS, CLK_PERIOD_PS), HOLD_CYC + 1);
  localparam int unsigned TAIL_CYC  = RAS_CYC - HOLD_CYC;
  localparam int unsigned PRECH_CYC = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RAW_INT   = ((RETENTION_NS / ROW_COUNT) * 1000) / CLK_PERIOD_PS;
  localparam int unsigned INTERVAL_CYC = max2(RAW_INT, LEAD_CYC + RAS_CYC + PRECH_CYC + 1);

  ctrl_strobe_t ctrlStrobe;
  logic phaseDone, pendingAny, casActive, rasActive;

  refresh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refGrant   (refGrant),
    .phaseDone  (phaseDone),
    .pendingAny (pendingAny),
    .ctrl       (ctrlStrobe),
    .refReq     (refReq),
    .refBusy    (refBusy),
    .casActive  (casActive),
    .rasActive  (rasActive)
  );

  refresh_datapath #(
    .LEAD_CYC     (LEAD_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .TAIL_CYC     (TAIL_CYC),
    .PRECH_CYC    (PRECH_CYC),
    .INTERVAL_CYC (INTERVAL_CYC),
    .MAX_PENDING  (MAX_PENDING),
    .URGENT_LEVEL (URGENT_LEVEL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlStrobe),
    .phaseDone  (phaseDone),
    .pendingAny (pendingAny),
    .urgent     (refUrgent)
  );

  // one driver per lane, all lanes share the same phase decode
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rasN[g] = ~rasActive;
    assign casN[g] = ~casActive;
  end

  assign weN = 1'b1;

endmodule

// File: rtl/cbr_refresh_checker.sv
`timescale 1ns/1ps
module cbr_refresh_checker
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned T_RAS_MAX_NS  = 10000,
  parameter int unsigned LANES         = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             refGrant,
  input logic             refReq,
  input logic             refUrgent,
  input logic             refBusy,
  input logic [LANES-1:0] rasN,
  input logic [LANES-1:0] casN,
  input logic             weN
);

  localparam int unsigned RP_CYC      = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RAS_MAX_CYC = (T_RAS_MAX_NS * 1000) / CLK_PERIOD_PS;
  localparam int unsigned HI_W        = $clog2(RP_CYC + 1);
  localparam int unsigned LO_W        = $clog2(RAS_MAX_CYC + 1) + 1;

  logic [HI_W-1:0] highCnt;
  logic [LO_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= HI_W'(RP_CYC);
      lowCnt  <= '0;
    end else if (rasN[0]) begin
      lowCnt  <= '0;
      if (highCnt != HI_W'(RP_CYC)) highCnt <= highCnt + 1'b1;
    end else begin
      highCnt <= '0;
      if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
    end
  end

  // R3
  casLeadsRas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (!casN[0] && !$past(casN[0])));

  // R4
  rasMaxWidth_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN[0] |-> (lowCnt < LO_W'(RAS_MAX_CYC)));

  // R5
  weHighAtRas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (weN && $past(weN)));

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (highCnt >= HI_W'(RP_CYC)));

  // R6
  busyNoReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |-> !refReq);

  // R7
  lanesTogether_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rasN == '0) || (rasN == '1)) && ((casN == '0) || (casN == '1)));

  // R9
  urgentHasWork_chk: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> (refReq || refBusy));

  // R10
  idleGrantIgnored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refBusy && !refReq && refGrant) |=> !refBusy);

endmodule

bind cbr_refresh_engine cbr_refresh_checker #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_RP_NS       (T_RP_NS),
  .T_RAS_MAX_NS  (10000),
  .LANES         (LANES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refGrant  (refGrant),
  .refReq    (refReq),
  .refUrgent (refUrgent),
  .refBusy   (refBusy),
  .rasN      (rasN),
  .casN      (casN),
  .weN       (weN)
);

// File: tb/cbr_refresh_engine_test.sv
`timescale 1ns/1ps
module cbr_refresh_engine_test;

  // bench copy of the timing rules at a 10 ns clock
  localparam int INTERVAL = 400;  // 4096000 ns / 1024 rows / 10 ns
  localparam int LEAD     = 1;    // max(ceil(5/10), ceil(10/10))
  localparam int HOLD     = 1;    // max(ceil(10/10), ceil(10/10))
  localparam int RASLEN   = 6;    // ceil(60/10)
  localparam int PRECH    = 4;    // ceil(40/10)
  localparam int TOTAL    = LEAD + RASLEN + PRECH;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refGrant = 1'b0;
  logic       refReq, refUrgent, refBusy, weN;
  logic [3:0] rasN, casN;

  int testsRun = 0;
  int testsFailed = 0;
  int edgeCnt = 0;
  bit timedOut = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  cbr_refresh_engine #(.RETENTION_NS(4096000)) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .refUrgent(refUrgent), .refBusy(refBusy), .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, edgeCnt);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; refGrant = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitEdge(input int target);
    while (edgeCnt < target) @(negedge clk);
  endtask

  task automatic pulseGrant();
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
  endtask

  // called right after pulseGrant, i.e. in cycle 1 of the refresh
  task automatic checkSequence();
    for (int i = 1; i <= TOTAL + 1; i++) begin
      int expCas, expRas, expBusy;
      if (i > 1) @(negedge clk);
      expCas  = (i <= LEAD + HOLD) ? 0 : 1;
      expRas  = (i > LEAD && i <= LEAD + RASLEN) ? 0 : 1;
      expBusy = (i <= TOTAL) ? 1 : 0;
      check(casN[0] == expCas, "R3", "casN lane0", casN[0], expCas);
      check(rasN[0] == expRas, "R4", "rasN lane0", rasN[0], expRas);
      check(weN == 1'b1, "R5", "weN", weN, 1);
      check(refBusy == expBusy, "R6", "refBusy", refBusy, expBusy);
      check((rasN == {4{rasN[0]}}) && (casN == {4{casN[0]}}), "R7", "lanes equal",
            {rasN, casN}, {{4{rasN[0]}}, {4{casN[0]}}});
      if (expBusy == 1) check(refReq == 1'b0, "R6", "refReq while busy", refReq, 0);
    end
  endtask

  task automatic t_reset();
    doReset();
    @(negedge clk);
    check(rasN == 4'hF, "R2", "rasN", rasN, 15);
    check(casN == 4'hF, "R2", "casN", casN, 15);
    check(weN == 1'b1, "R2", "weN", weN, 1);
    check({refReq, refBusy, refUrgent} == 3'b000, "R2", "req/busy/urgent",
          {refReq, refBusy, refUrgent}, 0);
  endtask

  task automatic t_grantNoPending();
    doReset();
    pulseGrant();
    check(refBusy == 1'b0, "R10", "busy after idle grant", refBusy, 0);
    @(negedge clk);
    check(casN == 4'hF && rasN == 4'hF, "R10", "strobes after idle grant",
          {rasN, casN}, 255);
  endtask

  task automatic t_intervalAndSequence();
    doReset();
    waitEdge(INTERVAL - 1);
    check(refReq == 1'b0, "R1", "refReq before interval", refReq, 0);
    waitEdge(INTERVAL);
    check(refReq == 1'b1, "R1", "refReq at interval", refReq, 1);
    pulseGrant();
    checkSequence();
    check(refReq == 1'b0, "R1", "refReq after drain", refReq, 0);
    waitEdge(2 * INTERVAL - 1);
    check(refReq == 1'b0, "R1", "refReq before second interval", refReq, 0);
    waitEdge(2 * INTERVAL);
    check(refReq == 1'b1, "R1", "refReq at second interval", refReq, 1);
  endtask

  task automatic t_grantWhileBusy();
    doReset();
    waitEdge(2 * INTERVAL + 1);   // two pending
    pulseGrant();                 // cycle 1
    repeat (2) @(negedge clk);    // cycle 3
    refGrant = 1'b1;
    @(negedge clk);               // cycle 4
    refGrant = 1'b0;
    check(refBusy == 1'b1, "R10", "busy mid-cycle", refBusy, 1);
    check(refReq == 1'b0, "R6", "refReq mid-cycle", refReq, 0);
    repeat (TOTAL + 1 - 4) @(negedge clk);  // cycle TOTAL+1
    check(refBusy == 1'b0, "R6", "idle after precharge", refBusy, 0);
    check(refReq == 1'b1, "R10", "one refresh left", refReq, 1);
    pulseGrant();
    repeat (TOTAL) @(negedge clk);
    check(refReq == 1'b0, "R10", "drained after two", refReq, 0);
  endtask

  task automatic t_urgentAndSaturation();
    doReset();
    waitEdge(4 * INTERVAL - 1);
    check(refUrgent == 1'b0, "R9", "urgent at three pending", refUrgent, 0);
    waitEdge(4 * INTERVAL);
    check(refUrgent == 1'b1, "R9", "urgent at four pending", refUrgent, 1);
    waitEdge(10 * INTERVAL + 10);   // ten intervals, capped at eight
    for (int k = 1; k <= 8; k++) begin
      pulseGrant();
      repeat (TOTAL) @(negedge clk);
      check(refUrgent == ((8 - k) >= 4), "R9", "urgent while draining",
            refUrgent, ((8 - k) >= 4));
      check(refReq == ((8 - k) > 0), "R8", "refReq while draining",
            refReq, ((8 - k) > 0));
    end
  endtask

  task automatic t_tickAndTake();
    doReset();
    waitEdge(2 * INTERVAL - 1);     // one pending; grant lands on the tick edge
    pulseGrant();
    repeat (TOTAL) @(negedge clk);
    check(refReq == 1'b1, "R11", "count kept on collision", refReq, 1);
    pulseGrant();
    repeat (TOTAL) @(negedge clk);
    check(refReq == 1'b0, "R11", "drained after collision", refReq, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_grantNoPending();
        t_intervalAndSequence();
        t_grantWhileBusy();
        t_urgentAndSaturation();
        t_tickAndTake();
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule